// File: doc/BRIEF.md
# Cascadable Up/Down Counter with Preset

A four-bit counter whose flip-flops all update together on the rising clock edge. An active-low load presets it from a data word. Two active-low enables must both be low for it to step. A direction input chooses up or down. A parameter fixes the counting range: decade (0 to 9) or full binary (0 to 15).

An active-low carry output flags the terminal state for the selected direction. The carry is gated by only one of the two enables, the T enable. Wiring one stage's carry into the T enable of the next stage builds a wider synchronous counter with no extra gates. The shared P enable and load still reach every stage.

Control inputs are sampled only at the clock edge. What they do between edges has no effect.

Top module: `updn_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the count becomes 0 at that edge.
- R2: With `load_n` low at an edge, the count takes the value of `d` at that edge, whatever the enables and direction are.
- R3: With `load_n` high and either `enp_n` or `ent_n` high, the count holds its value across the edge.
- R4: With `load_n`, `enp_n` and `ent_n` sampled high, low and low, and `up` high, the count rises by one per edge. It wraps from the top value to 0: 9 in decade mode, 15 in binary mode.
- R5: Under the same enables with `up` low, the count falls by one per edge. It wraps from 0 to the top value.
- R6: `rco_n` is combinational. It is low only when `ent_n` is low and the count is terminal for the current direction: the top value when counting up, 0 when counting down. It is high whenever `ent_n` is high, whatever `enp_n` is.
- R7: In decade mode, a loaded count of 10 to 15 steps up through the remaining codes to 15 and then to 0, and steps down by one. No code locks up, and 15 is not a terminal value for the carry.
- R8: Two decade stages share clock, load, P enable and direction, and the lower stage's `rco_n` drives the upper stage's `ent_n`. The pair then counts as two BCD digits in both directions, wrapping 99 to 00 and 00 to 99.
- R9: Pulses on `load_n` or the enables that return to their former level before the next edge leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_n | input | 1 | Active-low synchronous preset |
| d | input | W | Preset value |
| enp_n | input | 1 | Active-low count enable P (count only) |
| ent_n | input | 1 | Active-low count enable T (count and carry) |
| up | input | 1 | 1 counts up, 0 counts down |
| q | output | W | Current count |
| rco_n | output | 1 | Active-low terminal-count carry |

## Verification
If a stage holds a wrong count, it shows on `q` at the very edge where it is loaded or stepped. In a cascade it also shows one edge later in the upper digit, because the false or missing carry lets that digit step when it should not, or stops it when it should. A wrong terminal decode shows at once on `rco_n`, in the same cycle, since the carry is combinational. The vector walk therefore compares both digits and the top carry after every edge. The directed tests cover the codes that a decade stage never reaches by counting alone.

// File: rtl/ctr_pkg.sv
`timescale 1ns/1ps
// Shared types for the counter: the operation chosen at each edge.
package ctr_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_UP   = 2'd2,
        OP_DOWN = 2'd3
    } ctr_op_e;
endpackage

// File: rtl/ctr_ctrl.sv
`timescale 1ns/1ps
// Decodes the control inputs into one operation, with load taking priority.
// Assumes the inputs are already synchronous to the counter clock.
module ctr_ctrl
    import ctr_pkg::*;
(
    input  logic    load_n,
    input  logic    enp_n,
    input  logic    ent_n,
    input  logic    up,
    output ctr_op_e op
);
    // Priority decode: load, then count (both enables low), else hold.
    always_comb begin
        if (!load_n)               op = OP_LOAD;
        else if (!enp_n && !ent_n) op = up ? OP_UP : OP_DOWN;
        else                       op = OP_HOLD;
    end
endmodule

// File: rtl/ctr_next.sv
`timescale 1ns/1ps
// Next-state arithmetic for one counter stage.
// TOP is the terminal value for counting up. Codes above TOP climb
// until the natural all-ones wrap.
module ctr_next
    import ctr_pkg::*;
#(
    parameter int W   = 4,
    parameter int TOP = 9
) (
    input  ctr_op_e      op,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] din,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] TOPV = W'(TOP);

    // Select the value the state register takes at the next edge.
    always_comb begin
        unique case (op)
            OP_LOAD: nxt = din;
            OP_UP:   nxt = (cur == TOPV) ? '0 : cur + 1'b1;
            OP_DOWN: nxt = (cur == '0) ? TOPV : cur - 1'b1;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_term.sv
`timescale 1ns/1ps
// Terminal-count detect and active-low carry gated by enable T.
// DECADE picks a compare against TOP, or an all-ones test in binary mode.
module ctr_term #(
    parameter int W      = 4,
    parameter int TOP    = 9,
    parameter bit DECADE = 1'b1
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    input  logic         ent_n,
    output logic         rco_n
);
    localparam logic [W-1:0] TOPV = W'(TOP);

    logic at_top;

    generate
        if (DECADE) begin : g_dec
            // Decade stage: terminal only at the decade top value.
            assign at_top = (cur == TOPV);
        end else begin : g_bin
            // Binary stage: terminal when every bit is set.
            assign at_top = &cur;
        end
    endgenerate

    // Carry goes low only with T low and the count terminal for the direction.
    always_comb begin
        rco_n = ~(~ent_n & (up ? at_top : (cur == '0)));
    end
endmodule

// File: rtl/updn_counter.sv
`timescale 1ns/1ps
// Presettable synchronous up/down counter, decade or binary by parameter.
// Assumes the control inputs are stable around the rising clock edge.
// The carry is combinational, so it can enable a following stage.
module updn_counter
    import ctr_pkg::*;
#(
    parameter int W      = 4,
    parameter bit DECADE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic [W-1:0] d,
    input  logic         enp_n,
    input  logic         ent_n,
    input  logic         up,
    output logic [W-1:0] q,
    output logic         rco_n
);
    localparam int TOP = DECADE ? 9 : (1 << W) - 1;

    ctr_op_e      op;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    ctr_ctrl u_ctrl (
        .load_n (load_n),
        .enp_n  (enp_n),
        .ent_n  (ent_n),
        .up     (up),
        .op     (op)
    );

    ctr_next #(.W(W), .TOP(TOP)) u_next (
        .op  (op),
        .cur (cnt_q),
        .din (d),
        .nxt (cnt_d)
    );

    ctr_term #(.W(W), .TOP(TOP), .DECADE(DECADE)) u_term (
        .cur   (cnt_q),
        .up    (up),
        .ent_n (ent_n),
        .rco_n (rco_n)
    );

    // State register: synchronous reset, otherwise take the next value.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign q = cnt_q;
endmodule

// File: rtl/updn_counter_chk.sv
`timescale 1ns/1ps
// Property checker for updn_counter, bound to every instance.
module updn_counter_chk #(
    parameter int W      = 4,
    parameter bit DECADE = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load_n,
    input logic [W-1:0] d,
    input logic         enp_n,
    input logic         ent_n,
    input logic         up,
    input logic [W-1:0] q,
    input logic         rco_n
);
    localparam logic [W-1:0] TOPV = DECADE ? W'(9) : '1;
    localparam logic [W-1:0] MAXV = '1;

    logic step;
    assign step = load_n && !enp_n && !ent_n;

    // R2: a load lands on the next edge.
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> q == $past(d));

    // R3: either enable high holds the count.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (enp_n || ent_n)) |=> $stable(q));

    // R4: up step below the wrap points.
    p_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && up && q != TOPV && q != MAXV) |=> q == W'($past(q) + 1'b1));

    // R4, R7: wrap to zero from top or all-ones.
    p_upwrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && up && (q == TOPV || q == MAXV)) |=> q == '0);

    // R5: down step above zero.
    p_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !up && q != '0) |=> q == W'($past(q) - 1'b1));

    // R5: down wrap from zero to top.
    p_downwrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !up && q == '0) |=> q == TOPV);

    // R6: T high forces the carry inactive.
    p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ent_n |-> rco_n);

    // R6: an active carry implies a terminal count.
    p_term_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rco_n |-> (up ? q == TOPV : q == '0));
endmodule

bind updn_counter updn_counter_chk #(.W(W), .DECADE(DECADE)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_n (load_n),
    .d      (d),
    .enp_n  (enp_n),
    .ent_n  (ent_n),
    .up     (up),
    .q      (q),
    .rco_n  (rco_n)
);

// File: tb/updn_counter_test.sv
`timescale 1ns/1ps
module updn_counter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1, enp_n = 1'b1, ent_n = 1'b1, up = 1'b1;
    logic [7:0] d = 8'h00;
    logic [3:0] q_lo, q_hi;
    logic       rco_lo, rco_hi;
    logic       b_load_n = 1'b1, b_enp_n = 1'b1, b_ent_n = 1'b1, b_up = 1'b1;
    logic [3:0] b_d = 4'h0, b_q;
    logic       b_rco;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    updn_counter #(.W(4), .DECADE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .d(d[3:0]),
        .enp_n(enp_n), .ent_n(ent_n), .up(up), .q(q_lo), .rco_n(rco_lo));
    updn_counter #(.W(4), .DECADE(1'b1)) uut_hi (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .d(d[7:4]),
        .enp_n(enp_n), .ent_n(rco_lo), .up(up), .q(q_hi), .rco_n(rco_hi));
    updn_counter #(.W(4), .DECADE(1'b0)) uut_bin (
        .clk(clk), .rst_n(rst_n), .load_n(b_load_n), .d(b_d),
        .enp_n(b_enp_n), .ent_n(b_ent_n), .up(b_up), .q(b_q), .rco_n(b_rco));

    // Row: {load_n, enp_n, ent_n, up, d[7:0], expected BCD pair, expected top carry}
    localparam int NV = 14;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0,1'b1,1'b1,1'b1,8'h98,8'h98,1'b1},
        {1'b1,1'b0,1'b0,1'b1,8'h00,8'h99,1'b0},
        {1'b1,1'b0,1'b0,1'b1,8'h00,8'h00,1'b1},
        {1'b1,1'b0,1'b0,1'b1,8'h00,8'h01,1'b1},
        {1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0},
        {1'b1,1'b0,1'b0,1'b0,8'h00,8'h99,1'b1},
        {1'b1,1'b0,1'b0,1'b0,8'h00,8'h98,1'b1},
        {1'b1,1'b1,1'b0,1'b0,8'h00,8'h98,1'b1},
        {1'b1,1'b0,1'b1,1'b0,8'h00,8'h98,1'b1},
        {1'b0,1'b0,1'b0,1'b1,8'h45,8'h45,1'b1},
        {1'b1,1'b0,1'b0,1'b1,8'h00,8'h46,1'b1},
        {1'b0,1'b0,1'b0,1'b1,8'h09,8'h09,1'b1},
        {1'b1,1'b0,1'b0,1'b1,8'h00,8'h10,1'b1},
        {1'b1,1'b0,1'b0,1'b0,8'h00,8'h09,1'b1}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 50000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        tick(); tick();
        check("R1 cascade reset", {q_hi, q_lo}, 8'h00);
        check("R1 binary reset", {4'h0, b_q}, 8'h00);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6 R8: cascade vector walk
        for (int i = 0; i < NV; i++) begin
            {load_n, enp_n, ent_n, up, d} = VEC[i][20:9];
            tick();
            check($sformatf("R8 row %0d count", i), {q_hi, q_lo}, VEC[i][8:1]);
            check($sformatf("R6 row %0d carry", i), {7'h0, rco_hi}, {7'h0, VEC[i][0]});
        end

        // R6: T high blocks the lower carry at 9 counting up
        load_n = 1'b0; d = 8'h09; enp_n = 1'b1; ent_n = 1'b1; up = 1'b1;
        tick();
        load_n = 1'b1; #1;
        check("R6 gate T high", {7'h0, rco_lo}, 8'h01);
        ent_n = 1'b0; #1;
        check("R6 carry at 9 up", {7'h0, rco_lo}, 8'h00);

        // R7: decade stage loaded out of range
        load_n = 1'b0; d = 8'h0C; enp_n = 1'b0; ent_n = 1'b0; up = 1'b1;
        tick();
        load_n = 1'b1;
        tick();
        check("R7 12 up", {q_hi, q_lo}, 8'h0D);
        tick(); tick();
        check("R7 reach 15", {q_hi, q_lo}, 8'h0F);
        check("R7 no carry at 15", {7'h0, rco_lo}, 8'h01);
        tick();
        check("R7 15 wraps to 0", {q_hi, q_lo}, 8'h00);
        load_n = 1'b0; d = 8'h0C;
        tick();
        load_n = 1'b1; up = 1'b0;
        tick();
        check("R7 12 down", {q_hi, q_lo}, 8'h0B);

        // R9: pulses that return before the edge have no effect
        enp_n = 1'b1; ent_n = 1'b1; up = 1'b1;
        load_n = 1'b0; d = 8'h77; enp_n = 1'b0; ent_n = 1'b0;
        #1;
        load_n = 1'b1; enp_n = 1'b1; ent_n = 1'b1;
        tick();
        check("R9 glitch ignored", {q_hi, q_lo}, 8'h0B);

        // R4 R5 R6: binary stage wraps and carry
        b_load_n = 1'b0; b_d = 4'hE;
        tick();
        b_load_n = 1'b1; b_enp_n = 1'b0; b_ent_n = 1'b0; b_up = 1'b1;
        tick();
        check("R4 binary 14 to 15", {4'h0, b_q}, 8'h0F);
        check("R6 binary carry at 15", {7'h0, b_rco}, 8'h00);
        tick();
        check("R4 binary wrap 15 to 0", {4'h0, b_q}, 8'h00);
        b_up = 1'b0; #1;
        check("R6 binary carry at 0 down", {7'h0, b_rco}, 8'h00);
        tick();
        check("R5 binary wrap 0 to 15", {4'h0, b_q}, 8'h0F);
        b_up = 1'b1; b_ent_n = 1'b1; #1;
        check("R6 binary gated", {7'h0, b_rco}, 8'h01);
        tick();
        check("R3 binary hold T high", {4'h0, b_q}, 8'h0F);

        // R1: reset during operation
        rst_n = 1'b0;
        tick();
        check("R1 mid-run reset", {q_hi, q_lo}, 8'h00);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule